// File: doc/BRIEF.md
# Hardened Register File with Selectable Fault Protection

This block is a 32-entry, 32-bit register file for parts that must tolerate bit upsets in their storage. Each entry carries its own protection scheme, chosen by a mode field given with every write: plain storage, a single-error-correcting and double-error-detecting code, three copies with a bitwise majority vote, two plain copies, or two coded copies. The value is encoded on the way in. On the way out it is checked, repaired where the scheme allows, and returned.

Each read produces, one clock later, the read data and a valid flag. It also produces at most one of two event pulses: one for an error that was repaired and one for an error that could not be repaired. Counting these pulses is left to the surrounding logic. A separate fault-injection port overwrites the low 32 stored bits of any entry directly, without encoding, so that upsets can be planted and the repair path exercised. The system never drives this port in a cycle where it uses the normal read or write port.

Top module: `hardened_regfile`

## Requirements
- R1: A write stores `wr_data` under the 3-bit `wr_mode` in the entry picked by the 5-bit `wr_addr` (0 = plain, 1 = coded, 2 = three copies, 3 = two copies, 4 = two coded copies). With no upset, a later read of that entry returns the value with neither event pulse, in every mode.
- R2: `rd_data`, `rd_valid` and both event pulses are registered. They reflect a read strobed in cycle N at cycle N+1. In a cycle after no read, `rd_valid` and both pulses are low and `rd_data` keeps its last value.
- R3: In plain mode the stored bits are returned as they are, including any planted upset, and no event pulse is ever raised.
- R4: In coded mode the data bits sit unencoded in the low 32 stored bits, with 7 check bits above them. A single flipped data bit is repaired and raises `ev_corrected`.
- R5: In coded mode two flipped data bits raise `ev_uncorrectable`, and the stored data bits are returned unrepaired.
- R6: In three-copy mode (copy 0 in the low 32 bits) the result is the bitwise majority of the copies. Any disagreement raises `ev_corrected`, and `ev_uncorrectable` is never raised.
- R7: In two-copy mode (primary in the low 32 bits) a mismatch between the copies raises `ev_uncorrectable`, and the primary copy is returned.
- R8: In two-coded-copy mode a repairable upset in the primary copy is repaired. An unrepairable primary copy falls back to the shadow copy. Both cases raise `ev_corrected`.
- R9: A fault injection replaces only the low 32 stored bits of the addressed entry. The mode and all other stored bits are kept, and a later normal write stores a clean encoding again.
- R10: Reset clears every stored bit and every mode field, so a read after reset returns zero with no event pulse.
- R11: A read and a write to the same entry in the same cycle return the contents from before the write. The new value is seen from the next read on.
- R12: The mode codes 5 to 7 behave as plain storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Entry to write |
| wr_data | input | 32 | Value to store |
| wr_mode | input | 3 | Protection mode for the written entry |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 5 | Entry to read |
| rd_data | output | 32 | Checked and repaired read value |
| rd_valid | output | 1 | High for one cycle after a read strobe |
| ev_corrected | output | 1 | The read hit an error that was repaired |
| ev_uncorrectable | output | 1 | The read hit an error that could not be repaired |
| inj_en | input | 1 | Fault-injection strobe |
| inj_addr | input | 5 | Entry whose raw bits are overwritten |
| inj_data | input | 32 | Raw value for the low 32 stored bits |

## Verification
A read and a write can land on the same entry in the same clock. The bench provokes this by raising both strobes together on one address whose old and new values differ. It judges the registered result against the old value, and then judges a follow-up read against the new one. The event pulses of a repaired read can also meet the next idle cycle. The bench therefore samples the cycle after every flagged read and requires the pulses to be low and the data to be held there.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
  localparam int DATA_W  = 32;
  localparam int HAM_W   = 6;
  localparam int CHK_W   = HAM_W + 1;
  localparam int CW_W    = DATA_W + CHK_W;
  localparam int HAM_POS = DATA_W + HAM_W;
  localparam int RAW_W   = 3 * DATA_W;
  localparam int MODE_W  = 3;

  typedef logic [MODE_W-1:0] prot_mode_t;

  localparam prot_mode_t MODE_PLAIN       = 3'd0;
  localparam prot_mode_t MODE_SECDED      = 3'd1;
  localparam prot_mode_t MODE_TRIPLE      = 3'd2;
  localparam prot_mode_t MODE_DUAL        = 3'd3;
  localparam prot_mode_t MODE_DUAL_SECDED = 3'd4;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              corr;
    logic              unc;
  } rd_res_t;

  // Hamming check bits: data bits occupy the non power-of-two positions 1..HAM_POS
  function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    int k;
    h = '0;
    k = 0;
    for (int pos = 1; pos <= HAM_POS; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (d[k]) h = h ^ pos[HAM_W-1:0];
        k++;
      end
    end
    return h;
  endfunction

  // Hamming bits plus an overall parity bit that makes the codeword even
  function automatic logic [CHK_W-1:0] chk_bits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = ham_bits(d);
    return {(^d) ^ (^h), h};
  endfunction

  function automatic logic [RAW_W-1:0] encode_word(input prot_mode_t m,
                                                   input logic [DATA_W-1:0] d);
    logic [CW_W-1:0] cw;
    cw = {chk_bits(d), d};
    case (m)
      MODE_SECDED:      return {{(RAW_W-CW_W){1'b0}}, cw};
      MODE_TRIPLE:      return {d, d, d};
      MODE_DUAL:        return {{(RAW_W-2*DATA_W){1'b0}}, d, d};
      MODE_DUAL_SECDED: return {{(RAW_W-2*CW_W){1'b0}}, cw, cw};
      default:          return {{(RAW_W-DATA_W){1'b0}}, d};
    endcase
  endfunction
endpackage

// File: rtl/hrf_store.sv
module hrf_store
  import hrf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  prot_mode_t        wr_mode,
  input  logic              inj_en,
  input  logic [AW-1:0]     inj_addr,
  input  logic [DATA_W-1:0] inj_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [RAW_W-1:0]  rd_raw,
  output prot_mode_t        rd_mode
);
  logic [RAW_W-1:0] raw_arr  [DEPTH];
  prot_mode_t       mode_arr [DEPTH];
  logic [RAW_W-1:0] wr_word;

  assign wr_word = encode_word(wr_mode, wr_data);

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [RAW_W-1:0] raw_q, raw_d;
    prot_mode_t       mode_q, mode_d;
    logic             ld;

    always_comb begin
      ld     = 1'b0;
      raw_d  = raw_q;
      mode_d = mode_q;
      if (wr_en && (wr_addr == AW'(e))) begin
        ld     = 1'b1;
        raw_d  = wr_word;
        mode_d = wr_mode;
      end else if (inj_en && (inj_addr == AW'(e))) begin
        ld                   = 1'b1;
        raw_d[DATA_W-1:0]    = inj_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw_q  <= '0;
        mode_q <= MODE_PLAIN;
      end else if (ld) begin
        raw_q  <= raw_d;
        mode_q <= mode_d;
      end
    end

    assign raw_arr[e]  = raw_q;
    assign mode_arr[e] = mode_q;
  end

  assign rd_raw  = raw_arr[rd_addr];
  assign rd_mode = mode_arr[rd_addr];
endmodule

// File: rtl/hrf_secded_dec.sv
module hrf_secded_dec
  import hrf_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic              corr_o,
  output logic              unc_o
);
  logic [HAM_W-1:0] syn;
  logic             odd;

  always_comb begin
    int k;
    syn    = chk_i[HAM_W-1:0] ^ ham_bits(data_i);
    odd    = ^{chk_i, data_i};
    data_o = data_i;
    corr_o = 1'b0;
    unc_o  = 1'b0;
    k      = 0;
    if (odd) begin
      if (int'(syn) > HAM_POS) begin
        unc_o = 1'b1;
      end else begin
        corr_o = 1'b1;
        for (int pos = 1; pos <= HAM_POS; pos++) begin
          if ((pos & (pos - 1)) != 0) begin
            if (syn == HAM_W'(pos)) data_o[k] = ~data_i[k];
            k++;
          end
        end
      end
    end else if (syn != '0) begin
      unc_o = 1'b1;
    end
  end
endmodule

// File: rtl/hrf_recover.sv
module hrf_recover
  import hrf_pkg::*;
(
  input  prot_mode_t       mode_i,
  input  logic [RAW_W-1:0] raw_i,
  output rd_res_t          res_o
);
  logic [DATA_W-1:0] p_data, s_data;
  logic              p_corr, p_unc, s_corr, s_unc;
  logic [DATA_W-1:0] c0, c1, c2, maj;
  logic              split;

  hrf_secded_dec u_pri (
    .data_i (raw_i[DATA_W-1:0]),
    .chk_i  (raw_i[CW_W-1:DATA_W]),
    .data_o (p_data),
    .corr_o (p_corr),
    .unc_o  (p_unc)
  );

  hrf_secded_dec u_sec (
    .data_i (raw_i[CW_W+DATA_W-1:CW_W]),
    .chk_i  (raw_i[2*CW_W-1:CW_W+DATA_W]),
    .data_o (s_data),
    .corr_o (s_corr),
    .unc_o  (s_unc)
  );

  assign c0    = raw_i[DATA_W-1:0];
  assign c1    = raw_i[2*DATA_W-1:DATA_W];
  assign c2    = raw_i[3*DATA_W-1:2*DATA_W];
  assign maj   = (c0 & c1) | (c0 & c2) | (c1 & c2);
  assign split = (c0 != c1) || (c0 != c2);

  always_comb begin
    res_o.data = c0;
    res_o.corr = 1'b0;
    res_o.unc  = 1'b0;
    case (mode_i)
      MODE_SECDED: begin
        res_o.data = p_data;
        res_o.corr = p_corr;
        res_o.unc  = p_unc;
      end
      MODE_TRIPLE: begin
        res_o.data = maj;
        res_o.corr = split;
      end
      MODE_DUAL: begin
        res_o.unc  = (c0 != c1);
      end
      MODE_DUAL_SECDED: begin
        if (!p_unc) begin
          res_o.data = p_data;
          res_o.corr = p_corr || s_corr || s_unc;
        end else if (!s_unc) begin
          res_o.data = s_data;
          res_o.corr = 1'b1;
        end else begin
          res_o.data = p_data;
          res_o.unc  = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hardened_regfile.sv
module hardened_regfile
  import hrf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              ev_corrected,
  output logic              ev_uncorrectable,
  input  logic              inj_en,
  input  logic [AW-1:0]     inj_addr,
  input  logic [DATA_W-1:0] inj_data
);
  logic [1:0]        rs_q;
  logic              rst_sync_n;
  logic [RAW_W-1:0]  rd_raw_w;
  prot_mode_t        rd_mode_w;
  rd_res_t           res_w;

  logic [DATA_W-1:0] data_q, data_d;
  logic              vld_q, vld_d, cor_q, cor_d, unc_q, unc_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  hrf_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_mode  (wr_mode),
    .inj_en   (inj_en),
    .inj_addr (inj_addr),
    .inj_data (inj_data),
    .rd_addr  (rd_addr),
    .rd_raw   (rd_raw_w),
    .rd_mode  (rd_mode_w)
  );

  hrf_recover u_recover (
    .mode_i (rd_mode_w),
    .raw_i  (rd_raw_w),
    .res_o  (res_w)
  );

  always_comb begin
    data_d = rd_en ? res_w.data : data_q;
    vld_d  = rd_en;
    cor_d  = rd_en && res_w.corr;
    unc_d  = rd_en && res_w.unc;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
      cor_q  <= 1'b0;
      unc_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      vld_q  <= vld_d;
      cor_q  <= cor_d;
      unc_q  <= unc_d;
    end
  end

  assign rd_data          = data_q;
  assign rd_valid         = vld_q;
  assign ev_corrected     = cor_q;
  assign ev_uncorrectable = unc_q;
endmodule

// File: rtl/hrf_checker.sv
module hrf_checker (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic        inj_en,
  input logic [2:0]  rd_mode,
  input logic [31:0] rd_data,
  input logic        rd_valid,
  input logic        ev_corrected,
  input logic        ev_uncorrectable
);
  assert_valid_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_en |=> rd_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_en |=> (!rd_valid && !ev_corrected && !ev_uncorrectable && $stable(rd_data)));

  assert_plain_silent_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && rd_mode == 3'd0) |=> (!ev_corrected && !ev_uncorrectable));

  assert_single_event_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(ev_corrected && ev_uncorrectable));

  assert_vote_never_unc_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && rd_mode == 3'd2) |=> !ev_uncorrectable);

  assert_inject_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    inj_en |-> !(wr_en || rd_en));

  assert_reserved_silent_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && rd_mode >= 3'd5) |=> (!ev_corrected && !ev_uncorrectable));
endmodule

bind hardened_regfile hrf_checker u_chk (
  .clk              (clk),
  .rst_sync_n       (rst_sync_n),
  .wr_en            (wr_en),
  .rd_en            (rd_en),
  .inj_en           (inj_en),
  .rd_mode          (rd_mode_w),
  .rd_data          (rd_data),
  .rd_valid         (rd_valid),
  .ev_corrected     (ev_corrected),
  .ev_uncorrectable (ev_uncorrectable)
);

// File: tb/hardened_regfile_bench.sv
`timescale 1ns/1ps
module hardened_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en, inj_en;
  logic [4:0]  wr_addr, rd_addr, inj_addr;
  logic [31:0] wr_data, inj_data;
  logic [2:0]  wr_mode;
  logic [31:0] rd_data;
  logic        rd_valid, ev_corrected, ev_uncorrectable;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  hardened_regfile u_hardened_regfile (
    .clk (clk), .rst_n (rst_n),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data), .wr_mode (wr_mode),
    .rd_en (rd_en), .rd_addr (rd_addr),
    .rd_data (rd_data), .rd_valid (rd_valid),
    .ev_corrected (ev_corrected), .ev_uncorrectable (ev_uncorrectable),
    .inj_en (inj_en), .inj_addr (inj_addr), .inj_data (inj_data)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [31:0] wdata;
    logic [31:0] mask;
    logic [31:0] exp;
    logic        c;
    logic        u;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 32'h1234_5678, 32'h0000_0000, 32'h1234_5678, 1'b0, 1'b0, 8'd1},  // R1
    '{3'd1, 32'hDEAD_BEEF, 32'h0000_0000, 32'hDEAD_BEEF, 1'b0, 1'b0, 8'd1},  // R1
    '{3'd2, 32'h0F0F_A5A5, 32'h0000_0000, 32'h0F0F_A5A5, 1'b0, 1'b0, 8'd1},  // R1
    '{3'd3, 32'h8000_0001, 32'h0000_0000, 32'h8000_0001, 1'b0, 1'b0, 8'd1},  // R1
    '{3'd4, 32'hCAFE_F00D, 32'h0000_0000, 32'hCAFE_F00D, 1'b0, 1'b0, 8'd1},  // R1
    '{3'd0, 32'h0000_FFFF, 32'h0000_0001, 32'h0000_FFFE, 1'b0, 1'b0, 8'd3},  // R3
    '{3'd1, 32'h1357_9BDF, 32'h0000_0080, 32'h1357_9BDF, 1'b1, 1'b0, 8'd4},  // R4
    '{3'd1, 32'h2468_ACE0, 32'h8000_0000, 32'h2468_ACE0, 1'b1, 1'b0, 8'd4},  // R4
    '{3'd1, 32'h5555_AAAA, 32'h0000_0003, 32'h5555_AAA9, 1'b0, 1'b1, 8'd5},  // R5
    '{3'd2, 32'h7777_1111, 32'hFFFF_0000, 32'h7777_1111, 1'b1, 1'b0, 8'd6},  // R6
    '{3'd3, 32'h0BAD_CAFE, 32'h0000_0010, 32'h0BAD_CAEE, 1'b0, 1'b1, 8'd7},  // R7
    '{3'd4, 32'h3141_5926, 32'h0000_0100, 32'h3141_5926, 1'b1, 1'b0, 8'd8},  // R8
    '{3'd4, 32'h2718_2818, 32'h0000_0081, 32'h2718_2818, 1'b1, 1'b0, 8'd8},  // R8
    '{3'd5, 32'h0000_0F00, 32'h0000_0004, 32'h0000_0F04, 1'b0, 1'b0, 8'd12}, // R12
    '{3'd7, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 8'd12}, // R12
    '{3'd1, 32'hA0A0_A0A0, 32'h0000_0001, 32'hA0A0_A0A0, 1'b1, 1'b0, 8'd4}   // R4
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [4:0] a, input logic [2:0] m, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_mode = m; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_inject(input logic [4:0] a, input logic [31:0] d);
    inj_en = 1'b1; inj_addr = a; inj_data = d;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic do_read(input logic [4:0] a);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_read(input string tag, input logic [31:0] d, input logic c, input logic u);
    check({tag, " valid"}, {31'b0, rd_valid}, 32'd1);
    check({tag, " data"}, rd_data, d);
    check({tag, " corrected"}, {31'b0, ev_corrected}, {31'b0, c});
    check({tag, " uncorrectable"}, {31'b0, ev_uncorrectable}, {31'b0, u});
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 outputs in reset", {rd_data[30:0], rd_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    wr_en = 0; rd_en = 0; inj_en = 0;
    wr_addr = '0; rd_addr = '0; inj_addr = '0;
    wr_data = '0; inj_data = '0; wr_mode = '0;
    @(negedge clk);
    apply_reset();

    // R2 / R10: quiet state and cleared contents
    check("R2 idle valid after reset", {31'b0, rd_valid}, 32'd0);
    check("R2 idle data after reset", rd_data, 32'd0);
    do_read(5'd31);
    check_read("R10 entry 31 after reset", 32'd0, 1'b0, 1'b0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [4:0] a;
      a = 5'(2 * i);
      do_write(a, VEC[i].mode, VEC[i].wdata);
      if (VEC[i].mask != 32'd0) do_inject(a, VEC[i].wdata ^ VEC[i].mask);
      do_read(a);
      check_read($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp, VEC[i].c, VEC[i].u);
    end

    // R2: the cycle after a flagged read is quiet and holds the data
    do_write(5'd1, 3'd1, 32'h0C0F_FEE0);
    do_inject(5'd1, 32'h0C0F_FEE0 ^ 32'h0000_0400);
    do_read(5'd1);
    check_read("R2 flagged read", 32'h0C0F_FEE0, 1'b1, 1'b0);
    held = rd_data;
    @(negedge clk);
    check("R2 idle valid", {31'b0, rd_valid}, 32'd0);
    check("R2 idle corrected", {31'b0, ev_corrected}, 32'd0);
    check("R2 idle data held", rd_data, held);

    // R9: injection keeps mode and upper bits; a rewrite restores clean storage
    do_write(5'd5, 3'd2, 32'h6666_9999);
    do_inject(5'd5, 32'h9999_6666);
    do_read(5'd5);
    check_read("R9 vote over injected copy", 32'h6666_9999, 1'b1, 1'b0);
    do_write(5'd5, 3'd2, 32'h6666_9999);
    do_read(5'd5);
    check_read("R9 clean after rewrite", 32'h6666_9999, 1'b0, 1'b0);
    do_write(5'd7, 3'd1, 32'h0000_ABCD);
    do_inject(5'd7, 32'h0000_ABCF);
    do_read(5'd7);
    check_read("R9 mode and check bits kept", 32'h0000_ABCD, 1'b1, 1'b0);

    // R11: read and write on one entry in one cycle
    do_write(5'd9, 3'd0, 32'hAAAA_0001);
    wr_en = 1'b1; wr_addr = 5'd9; wr_mode = 3'd0; wr_data = 32'hBBBB_0002;
    rd_en = 1'b1; rd_addr = 5'd9;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check_read("R11 same-cycle read sees old", 32'hAAAA_0001, 1'b0, 1'b0);
    do_read(5'd9);
    check_read("R11 next read sees new", 32'hBBBB_0002, 1'b0, 1'b0);

    // R10: reset in the middle of operation clears stored data and modes
    apply_reset();
    do_read(5'd0);
    check_read("R10 entry 0 cleared", 32'd0, 1'b0, 1'b0);
    do_read(5'd12);
    check_read("R10 coded entry cleared", 32'd0, 1'b0, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule